// File: doc/BRIEF.md
# Valley-switching gate timer

This block drives the power-switch gate of a quasi-resonant flyback converter in normal operation. It alternates between an on phase and an off phase. During the off phase it counts the valleys of the drain ringing, which arrive as single-cycle zero-crossing pulses. It holds the gate low through a ringing mask whose length depends on the ringing level seen at turn-off. It then turns the gate on once the valley count reaches a target chosen elsewhere. If too few valleys appear, a maximum off time turns it on anyway.

During the on phase, a current-comparator flag ends the pulse. That flag is ignored for a short blanking window just after turn-on, and a maximum on time caps the pulse length. All durations are parameters counted in clock cycles. The analog comparators sit outside the block and deliver synchronous flags. Every pin is a plain level or a single-cycle pulse. No input is ever refused, so there is no valid/ready handshake and no back-pressure.

Top module: `qr_gate_timer`

## Requirements
- R1: While reset is asserted, `gate` is 0 and `zc_count` is 0.
- R2: While the gate is low, each clock cycle with `zc_pulse` high adds one to the 3-bit `zc_count`, which is visible in the next cycle. The count holds at 7 once it reaches 7, and the count is 0 in the first cycle after turn-off.
- R3: `zc_count` returns to 0 in the first cycle the gate is high and stays 0 for the whole on phase, whatever `zc_pulse` does.
- R4: After the gate falls, it stays low for at least SUPP_SHORT_CYC cycles if `ring_hi` was 1 in the last high cycle, and for at least SUPP_LONG_CYC cycles if it was 0. `ring_hi` has no effect at any other time.
- R5: Once the mask has elapsed, the gate rises at the first clock edge where the registered `zc_count` is greater than or equal to `valley_target`, compared as unsigned 3-bit values.
- R6: The gate is never low for more than OFF_MAX_CYC consecutive enabled cycles. At that limit it rises regardless of the counts.
- R7: `cs_trip` is ignored during the first LEB_CYC-1 high cycles, so every pulse lasts at least LEB_CYC cycles.
- R8: `cs_trip` high in high cycle LEB_CYC or later (counting from 1) makes that cycle the last high cycle.
- R9: Without `cs_trip`, the gate stays high for exactly ON_MAX_CYC cycles.
- R10: While `en` is 0, `gate` is 0 in the same cycle and the count and timers clear. After reset, or when `en` returns, an off phase starts with the long mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Switching enable; low forces the gate off and clears state |
| zc_pulse | input | 1 | Single-cycle pulse per falling zero crossing |
| ring_hi | input | 1 | Ringing-level comparator: 1 selects the short mask |
| cs_trip | input | 1 | Current-sense versus feedback comparator flag |
| valley_target | input | CNT_W | Number of valleys to wait before turn-on |
| gate | output | 1 | Gate drive command |
| zc_count | output | CNT_W | Valleys counted in the current off phase |

## Verification
The off phase is swept over every valley target from 0 to 7. For each target it runs with pulses on every cycle, sparse pulses from two different offsets, and no pulses at all. This separates turn-on by valley count, turn-on held back by the mask, and turn-on by the off-time limit, and the dense pattern also exercises saturation at 7. Each sweep point is repeated with both ringing levels at turn-off, while the flag toggles during the off phase. A mask taken from the wrong instant therefore shows up as a wrong off length. The on phase is driven with the trip flag rising before, at and after the end of blanking, and with no trip at all. Zero-crossing pulses are held high throughout the on phase, so pulses counted while the gate is high show up in `zc_count`. A mid-pulse disable checks the immediate gate drop and the long mask after the block is enabled again.

// File: rtl/qr_gate_pkg.sv
package qr_gate_pkg;

  // Switching phase of the gate sequencer.
  typedef enum logic {
    PH_OFF = 1'b0,
    PH_ON  = 1'b1
  } phase_e;

  // Largest of the timing limits; sizes the shared phase timer.
  function automatic int span_max(input int a, input int b, input int c,
                                  input int d, input int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/qr_valley_counter.sv
// Saturating count of zero-crossing pulses seen while counting is allowed.
module qr_valley_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             count_en,
  input  logic             zc_pulse,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic at_top;
  assign at_top = (count == CNT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (count_en && zc_pulse && !at_top) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/qr_phase_timer.sv
// Cycle counter for the current phase; clears on each phase change, saturates.
module qr_phase_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [TMR_W-1:0] value
);

  localparam logic [TMR_W-1:0] TMR_TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (clr) begin
      value <= '0;
    end else if (value != TMR_TOP) begin
      value <= value + 1'b1;
    end
  end

endmodule

// File: rtl/qr_supp_select.sv
// Captures the ringing level at turn-off and presents the last masked
// off-phase cycle index. Reset and disable select the long mask.
module qr_supp_select #(
  parameter int SHORT_CYC = 4,
  parameter int LONG_CYC  = 12,
  parameter int TMR_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             capture,
  input  logic             ring_hi,
  output logic [TMR_W-1:0] mask_last
);

  localparam logic [TMR_W-1:0] SHORT_LAST = TMR_W'(SHORT_CYC - 1);
  localparam logic [TMR_W-1:0] LONG_LAST  = TMR_W'(LONG_CYC - 1);

  logic short_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      short_q <= 1'b0;
    end else if (clr) begin
      short_q <= 1'b0;
    end else if (capture) begin
      short_q <= ring_hi;
    end
  end

  assign mask_last = short_q ? SHORT_LAST : LONG_LAST;

endmodule

// File: rtl/qr_gate_timer.sv
// Valley-switching gate sequencer for quasi-resonant operation.
module qr_gate_timer
  import qr_gate_pkg::*;
#(
  parameter int CNT_W          = 3,
  parameter int SUPP_SHORT_CYC = 312,
  parameter int SUPP_LONG_CYC  = 3125,
  parameter int OFF_MAX_CYC    = 5250,
  parameter int LEB_CYC        = 41,
  parameter int ON_MAX_CYC     = 3750
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             zc_pulse,
  input  logic             ring_hi,
  input  logic             cs_trip,
  input  logic [CNT_W-1:0] valley_target,
  output logic             gate,
  output logic [CNT_W-1:0] zc_count
);

  localparam int SPAN  = span_max(SUPP_SHORT_CYC, SUPP_LONG_CYC, OFF_MAX_CYC,
                                  LEB_CYC, ON_MAX_CYC);
  localparam int TMR_W = $clog2(SPAN + 1);

  localparam logic [TMR_W-1:0] OFF_LAST = TMR_W'(OFF_MAX_CYC - 1);
  localparam logic [TMR_W-1:0] LEB_LAST = TMR_W'(LEB_CYC - 1);
  localparam logic [TMR_W-1:0] ON_LAST  = TMR_W'(ON_MAX_CYC - 1);

  phase_e           phase_q;
  phase_e           phase_d;
  logic [TMR_W-1:0] tmr;
  logic [TMR_W-1:0] mask_last;
  logic             in_off;
  logic             in_on;
  logic             mask_done;
  logic             valleys_met;
  logic             off_expired;
  logic             trip_honoured;
  logic             on_expired;
  logic             turn_on;
  logic             turn_off;

  assign in_off = (phase_q == PH_OFF);
  assign in_on  = (phase_q == PH_ON);

  // Turn-on decision: mask elapsed and enough valleys, or off-time limit.
  assign mask_done   = (tmr >= mask_last);
  assign valleys_met = (zc_count >= valley_target);
  assign off_expired = (tmr >= OFF_LAST);
  assign turn_on     = en && in_off && ((mask_done && valleys_met) || off_expired);

  // Turn-off decision: comparator after blanking, or on-time limit.
  assign trip_honoured = cs_trip && (tmr >= LEB_LAST);
  assign on_expired    = (tmr >= ON_LAST);
  assign turn_off      = en && in_on && (trip_honoured || on_expired);

  always_comb begin
    phase_d = phase_q;
    if (!en) begin
      phase_d = PH_OFF;
    end else if (turn_on) begin
      phase_d = PH_ON;
    end else if (turn_off) begin
      phase_d = PH_OFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OFF;
    end else begin
      phase_q <= phase_d;
    end
  end

  qr_phase_timer #(
    .TMR_W (TMR_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!en || turn_on || turn_off),
    .value (tmr)
  );

  qr_valley_counter #(
    .CNT_W (CNT_W)
  ) u_valleys (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!en || turn_on),
    .count_en (in_off),
    .zc_pulse (zc_pulse),
    .count    (zc_count)
  );

  qr_supp_select #(
    .SHORT_CYC (SUPP_SHORT_CYC),
    .LONG_CYC  (SUPP_LONG_CYC),
    .TMR_W     (TMR_W)
  ) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!en),
    .capture   (turn_off),
    .ring_hi   (ring_hi),
    .mask_last (mask_last)
  );

  // Disable drops the gate in the same cycle, ahead of the phase register.
  assign gate = in_on && en;

endmodule

// File: rtl/qr_gate_timer_chk.sv
// Port-level timing checks for qr_gate_timer; run lengths tracked by counters.
module qr_gate_timer_chk #(
  parameter int CNT_W          = 3,
  parameter int SUPP_SHORT_CYC = 312,
  parameter int OFF_MAX_CYC    = 5250,
  parameter int LEB_CYC        = 41,
  parameter int ON_MAX_CYC     = 3750
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             gate,
  input logic [CNT_W-1:0] zc_count
);

  localparam logic [31:0] MIN_OFF = 32'(SUPP_SHORT_CYC);
  localparam logic [31:0] MAX_OFF = 32'(OFF_MAX_CYC);
  localparam logic [31:0] MIN_ON  = 32'(LEB_CYC);
  localparam logic [31:0] MAX_ON  = 32'(ON_MAX_CYC);

  logic [31:0] hi_run;
  logic [31:0] lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else if (!en) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      hi_run <= gate ? hi_run + 32'd1 : 32'd0;
      lo_run <= gate ? 32'd0 : lo_run + 32'd1;
    end
  end

  AST_ZC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && zc_count != '0 && zc_count != $past(zc_count))
      |-> (zc_count == $past(zc_count) + 1'b1)); // R2

  AST_ZC_QUIET_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (en && gate && $past(gate)) |-> (zc_count == '0)); // R3

  AST_MIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (en && gate && lo_run != 32'd0) |-> (lo_run >= MIN_OFF)); // R4

  AST_MAX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !gate) |-> (lo_run < MAX_OFF)); // R6

  AST_MIN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !gate && hi_run != 32'd0) |-> (hi_run >= MIN_ON)); // R7

  AST_MAX_ON: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (hi_run < MAX_ON)); // R9

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en) |-> (zc_count == '0)); // R10

endmodule

bind qr_gate_timer qr_gate_timer_chk #(
  .CNT_W          (CNT_W),
  .SUPP_SHORT_CYC (SUPP_SHORT_CYC),
  .OFF_MAX_CYC    (OFF_MAX_CYC),
  .LEB_CYC        (LEB_CYC),
  .ON_MAX_CYC     (ON_MAX_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .gate     (gate),
  .zc_count (zc_count)
);

// File: tb/qr_gate_timer_bench.sv
module qr_gate_timer_bench;

  localparam int CW    = 3;
  localparam int SHORT = 4;
  localparam int LONG  = 12;
  localparam int OFFM  = 30;
  localparam int LEB   = 3;
  localparam int ONM   = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic          zc_pulse;
  logic          ring_hi;
  logic          cs_trip;
  logic [CW-1:0] valley_target;
  logic          gate;
  logic [CW-1:0] zc_count;

  int vecs = 0;
  int errs = 0;

  always #4 clk = ~clk;

  qr_gate_timer #(
    .CNT_W          (CW),
    .SUPP_SHORT_CYC (SHORT),
    .SUPP_LONG_CYC  (LONG),
    .OFF_MAX_CYC    (OFFM),
    .LEB_CYC        (LEB),
    .ON_MAX_CYC     (ONM)
  ) u_qr_gate_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .zc_pulse      (zc_pulse),
    .ring_hi       (ring_hi),
    .cs_trip       (cs_trip),
    .valley_target (valley_target),
    .gate          (gate),
    .zc_count      (zc_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Entered at on-cycle 0 (gate just rose). Trip asserted from on-cycle trip_from.
  task automatic on_phase(input int trip_from, input bit ring);
    for (int k = 0; k < ONM + 2; k++) begin
      bit    exp_fall;
      string lbl;
      chk(zc_count == 0, "R3 count during on phase", int'(zc_count), 0);
      cs_trip  = (k >= trip_from);
      ring_hi  = ring;
      zc_pulse = 1'b1;
      exp_fall = ((k >= trip_from) && (k >= LEB - 1)) || (k == ONM - 1);
      if ((k >= trip_from) && (k >= LEB - 1)) lbl = (trip_from < LEB - 1) ? "R7 blanking" : "R8 trip";
      else if (k == ONM - 1)                  lbl = "R9 max on";
      else                                    lbl = (k >= trip_from) ? "R7 blanking" : "R9 on hold";
      tick();
      chk(gate == !exp_fall, lbl, int'(gate), int'(!exp_fall));
      if (exp_fall || gate != !exp_fall) break;
    end
    cs_trip  = 1'b0;
    zc_pulse = 1'b0;
  endtask

  // Entered at off-cycle 0. Pulses at start, start+period, ... (period 0: none).
  task automatic off_phase(input bit ring_at_off, input int tgt, input int start,
                           input int period, input bit long_mask);
    int sup;
    int cnt;
    sup = (long_mask || !ring_at_off) ? LONG : SHORT;
    cnt = 0;
    valley_target = CW'(tgt);
    for (int k = 0; k < OFFM + 2; k++) begin
      bit    pulse;
      bit    vmet;
      bit    exp_on;
      string lbl;
      chk(int'(zc_count) == cnt, "R2 valley count", int'(zc_count), cnt);
      pulse    = (period > 0) && (k >= start) && ((k - start) % period == 0);
      zc_pulse = pulse;
      ring_hi  = (k % 2 == 1);
      vmet     = (k >= sup - 1) && (cnt >= tgt);
      exp_on   = vmet || (k == OFFM - 1);
      if (vmet)               lbl = "R5 valley turn-on";
      else if (k == OFFM - 1) lbl = "R6 max off";
      else if (k < sup - 1)   lbl = long_mask ? "R10 long mask" : "R4 mask";
      else                    lbl = "R5 waiting";
      tick();
      if (pulse && cnt < 7) cnt++;
      chk(gate == exp_on, lbl, int'(gate), int'(exp_on));
      if (gate != exp_on) break;
      if (exp_on) begin
        chk(zc_count == 0, "R3 clear on rise", int'(zc_count), 0);
        break;
      end
    end
    zc_pulse = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R6 watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int trips [6];
    int starts[4];
    int pers  [4];
    int idx;
    trips  = '{0, 1, LEB - 1, LEB + 2, 8, 1000};
    starts = '{0, 2, 1, 0};
    pers   = '{1, 3, 5, 0};
    rst_n = 1'b0; en = 1'b1; zc_pulse = 1'b0; ring_hi = 1'b1; cs_trip = 1'b0;
    valley_target = '0;
    repeat (3) tick();
    chk(gate == 1'b0, "R1 reset gate", int'(gate), 0);
    chk(zc_count == 0, "R1 reset count", int'(zc_count), 0);
    rst_n = 1'b1;
    off_phase(1'b1, 0, 0, 0, 1'b1);

    idx = 0;
    for (int r = 0; r < 2; r++) begin
      for (int t = 0; t < 8; t++) begin
        for (int p = 0; p < 4; p++) begin
          on_phase(trips[idx % 6], r[0]);
          off_phase(r[0], t, starts[p], pers[p], 1'b0);
          idx++;
        end
      end
    end

    // Disable in the middle of a pulse, then re-enable.
    tick();
    tick();
    en = 1'b0;
    zc_pulse = 1'b1;
    #1;
    chk(gate == 1'b0, "R10 immediate gate drop", int'(gate), 0);
    repeat (3) tick();
    chk(gate == 1'b0, "R10 gate held low", int'(gate), 0);
    chk(zc_count == 0, "R10 count cleared", int'(zc_count), 0);
    en = 1'b1;
    zc_pulse = 1'b0;
    off_phase(1'b1, 0, 0, 0, 1'b1);
    finish_run();
  end

endmodule